// File: doc/BRIEF.md
# Memory Access Tracking Queue

The block is a circular queue that runs alongside a processor's reorder buffer and tracks only its memory-access instructions. An entry is allocated at dispatch, in the same cycle the instruction enters the reorder buffer. The entry stays in the queue after the instruction retires, and it is released from the head only once the access is both retired and performed. The counting logic downstream can then compare the interval number captured at perform time with the interval that is current at counting time.

When an access performs, the queue copies the current interval number into the entry. It also keeps the payload the counting logic may need to log. A load keeps the value it returned. A store keeps its write address and its write data. Speculative work is undone in the same way as in a reorder buffer: a squash names a queue index, and every entry younger than that index is dropped in one cycle. Perform and retire events address an entry by the index handed out at allocation.

Top module: `mem_trk_queue`

## Requirements
- R1: After reset the queue is empty. `full` is 0, `deq_valid` is 0, `alloc_ready` is 1 and `alloc_idx` is 0.
- R2: Allocations receive indices in order, starting at 0 and wrapping from DEPTH-1 back to 0. `alloc_idx` always shows the index the next allocation will receive, and a new entry starts neither retired nor performed.
- R3: `full` is 1 exactly when DEPTH entries are held. While `full` or `squash_valid` is 1, `alloc_ready` is 0 and an allocation request changes nothing.
- R4: A perform event stores the present `cur_interval` into the entry's interval tag and stores `perf_data` as its payload. A store entry (type 1) also keeps `perf_addr`. A load entry (type 0) reports an address of 0.
- R5: `deq_valid` is 1 only when the oldest entry is both retired and performed. It rises in the cycle after the later of the two events. The head leaves on a clock edge where `deq_valid` and `deq_ready` are both 1.
- R6: Entries leave strictly in allocation order. A ready entry behind an unready head is held back.
- R7: A retired store that has not yet performed stays in the queue and is not offered for counting.
- R8: A squash at index k keeps the entry at k and all older entries and drops all younger ones in a single cycle. The next allocation receives index k+1, modulo DEPTH.
- R9: An allocation and a head release in the same cycle both take effect, and the occupancy stays consistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Dispatch of a memory access |
| alloc_is_store | input | 1 | Access type: 1 for a store, 0 for a load |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | IDX_W | Index the next allocation will receive |
| full | output | 1 | No free entry |
| perf_valid | input | 1 | Perform event |
| perf_idx | input | IDX_W | Entry that performed |
| perf_addr | input | AW | Write address (used by stores) |
| perf_data | input | DW | Value loaded or value written |
| cur_interval | input | TW | Current interval number |
| ret_valid | input | 1 | Retire event |
| ret_idx | input | IDX_W | Entry that retired |
| squash_valid | input | 1 | Squash request |
| squash_idx | input | IDX_W | Youngest entry that survives the squash |
| deq_valid | output | 1 | Head entry is ready to be counted |
| deq_ready | input | 1 | Counting logic takes the head |
| deq_is_store | output | 1 | Head access type |
| deq_tag | output | TW | Interval number captured at perform |
| deq_addr | output | AW | Head store address (0 for a load) |
| deq_data | output | DW | Head load value or store data |

## Verification
The assertions assume that the inputs follow the rules of a well-behaved core. Perform and retire events name live entries only, and each entry performs once. Retirement follows program order. A squash names a live entry that has not retired, and no other event arrives in the squash cycle. The bench keeps within these rules because it draws every index from its own list of live entries. It retires the oldest entry not yet retired, and it squashes only at or behind that entry. It also sends any perform or retire only in a cycle without a squash.

// File: rtl/mtq_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the memory access tracking queue.
package mtq_pkg;
    // Access type held per entry and reported at the head.
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/mtq_ptr_ctrl.sv
`timescale 1ns/1ps
// Head/tail pointers and occupancy counter of the tracking queue.
// Assumes: squash_idx names a live entry; alloc_fire never occurs with squash.
module mtq_ptr_ctrl #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             deq_fire,
    input  logic             squash_valid,
    input  logic [IDX_W-1:0] squash_idx,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    localparam int               CNT_W = IDX_W + 1;
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP   = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] kept;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Entries surviving a squash: distance from head to squash_idx, plus one.
    always_comb begin
        if (squash_idx >= head)
            kept = {1'b0, squash_idx} - {1'b0, head} + CNT_W'(1);
        else
            kept = {1'b0, squash_idx} + CAP - {1'b0, head} + CNT_W'(1);
    end

    // Pointer and occupancy update; squash overrides tail and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (deq_fire)
                head <= step_idx(head);
            if (squash_valid) begin
                tail  <= step_idx(squash_idx);
                count <= kept - CNT_W'(deq_fire);
            end else begin
                if (alloc_fire)
                    tail <= step_idx(tail);
                count <= count + CNT_W'(alloc_fire) - CNT_W'(deq_fire);
            end
        end
    end

    assign full  = (count == CAP);
    assign empty = (count == '0);
endmodule

// File: rtl/mtq_entry_store.sv
`timescale 1ns/1ps
// Per-entry state of the tracking queue and the head read-out.
// Assumes: allocation and a perform/retire never target the same entry in one cycle.
module mtq_entry_store
    import mtq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [IDX_W-1:0] alloc_at,
    input  acc_kind_e        alloc_kind,
    input  logic             perf_valid,
    input  logic [IDX_W-1:0] perf_idx,
    input  logic [TW-1:0]    perf_tag,
    input  logic [AW-1:0]    perf_addr,
    input  logic [DW-1:0]    perf_data,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_idx,
    input  logic [IDX_W-1:0] head,
    output acc_kind_e        hd_kind,
    output logic             hd_retired,
    output logic             hd_performed,
    output logic [TW-1:0]    hd_tag,
    output logic [AW-1:0]    hd_addr,
    output logic [DW-1:0]    hd_data
);
    logic [DEPTH-1:0]    kind_v;
    logic [DEPTH-1:0]    ret_v;
    logic [DEPTH-1:0]    perf_v;
    logic [DEPTH*TW-1:0] tag_v;
    logic [DEPTH*AW-1:0] addr_v;
    logic [DEPTH*DW-1:0] data_v;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        acc_kind_e     kind_q;
        logic          ret_q;
        logic          perf_q;
        logic [TW-1:0] tag_q;
        logic [AW-1:0] addr_q;
        logic [DW-1:0] data_q;

        // One entry: cleared on allocation, marked by perform and retire events.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kind_q <= ACC_LOAD;
                ret_q  <= 1'b0;
                perf_q <= 1'b0;
                tag_q  <= '0;
                addr_q <= '0;
                data_q <= '0;
            end else if (alloc_fire && alloc_at == MY_IDX) begin
                kind_q <= alloc_kind;
                ret_q  <= 1'b0;
                perf_q <= 1'b0;
                tag_q  <= '0;
                addr_q <= '0;
                data_q <= '0;
            end else begin
                if (perf_valid && perf_idx == MY_IDX) begin
                    perf_q <= 1'b1;
                    tag_q  <= perf_tag;
                    data_q <= perf_data;
                    addr_q <= (kind_q == ACC_STORE) ? perf_addr : '0;
                end
                if (ret_valid && ret_idx == MY_IDX)
                    ret_q <= 1'b1;
            end
        end

        assign kind_v[g]             = (kind_q == ACC_STORE);
        assign ret_v[g]              = ret_q;
        assign perf_v[g]             = perf_q;
        assign tag_v[g*TW +: TW]     = tag_q;
        assign addr_v[g*AW +: AW]    = addr_q;
        assign data_v[g*DW +: DW]    = data_q;
    end

    assign hd_kind      = kind_v[head] ? ACC_STORE : ACC_LOAD;
    assign hd_retired   = ret_v[head];
    assign hd_performed = perf_v[head];
    assign hd_tag       = tag_v[head*TW +: TW];
    assign hd_addr      = addr_v[head*AW +: AW];
    assign hd_data      = data_v[head*DW +: DW];
endmodule

// File: rtl/mem_trk_queue.sv
`timescale 1ns/1ps
// Tracking queue for memory accesses running beside the reorder buffer.
// Entries live from dispatch until retired and performed; the head is then
// offered to the counting logic with its perform-time interval tag.
// Assumes: events address live entries, retirement in order, squash only
// at a non-retired live index with no other event in that cycle.
module mem_trk_queue
    import mtq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TW    = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             alloc_is_store,
    output logic             alloc_ready,
    output logic [IDX_W-1:0] alloc_idx,
    output logic             full,
    input  logic             perf_valid,
    input  logic [IDX_W-1:0] perf_idx,
    input  logic [AW-1:0]    perf_addr,
    input  logic [DW-1:0]    perf_data,
    input  logic [TW-1:0]    cur_interval,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_idx,
    input  logic             squash_valid,
    input  logic [IDX_W-1:0] squash_idx,
    output logic             deq_valid,
    input  logic             deq_ready,
    output logic             deq_is_store,
    output logic [TW-1:0]    deq_tag,
    output logic [AW-1:0]    deq_addr,
    output logic [DW-1:0]    deq_data
);
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic             empty;
    logic             alloc_fire;
    logic             deq_fire;
    acc_kind_e        hd_kind;
    logic             hd_retired;
    logic             hd_performed;

    assign alloc_ready = !full && !squash_valid;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_idx   = tail;
    assign deq_valid   = !empty && hd_retired && hd_performed;
    assign deq_fire    = deq_valid && deq_ready;
    assign deq_is_store = (hd_kind == ACC_STORE);

    mtq_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire   (alloc_fire),
        .deq_fire     (deq_fire),
        .squash_valid (squash_valid),
        .squash_idx   (squash_idx),
        .head         (head),
        .tail         (tail),
        .full         (full),
        .empty        (empty)
    );

    mtq_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW), .DW(DW), .TW(TW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire   (alloc_fire),
        .alloc_at     (tail),
        .alloc_kind   (alloc_is_store ? ACC_STORE : ACC_LOAD),
        .perf_valid   (perf_valid),
        .perf_idx     (perf_idx),
        .perf_tag     (cur_interval),
        .perf_addr    (perf_addr),
        .perf_data    (perf_data),
        .ret_valid    (ret_valid),
        .ret_idx      (ret_idx),
        .head         (head),
        .hd_kind      (hd_kind),
        .hd_retired   (hd_retired),
        .hd_performed (hd_performed),
        .hd_tag       (deq_tag),
        .hd_addr      (deq_addr),
        .hd_data      (deq_data)
    );
endmodule

// File: rtl/mtq_checker.sv
`timescale 1ns/1ps
// Protocol checker for the tracking queue, bound to the top module.
// Assumes the input rules listed in the top module header.
module mtq_checker #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             full,
    input logic             empty,
    input logic             squash_valid,
    input logic [IDX_W-1:0] squash_idx,
    input logic             deq_valid,
    input logic             deq_ready,
    input logic             deq_is_store,
    input logic [TW-1:0]    deq_tag,
    input logic [AW-1:0]    deq_addr,
    input logic [DW-1:0]    deq_data
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // R3: no allocation accepted while full.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ready);

    // R3: a full queue is never reported empty by the pointer logic.
    p_full_not_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !empty);

    // R2: an accepted allocation advances the next index by one, wrapping.
    p_alloc_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> alloc_idx == nxt($past(alloc_idx)));

    // R3: a refused allocation leaves the next index unchanged.
    p_refused_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready && !squash_valid) |=> $stable(alloc_idx));

    // R8: after a squash the next allocation follows the squash index.
    p_squash_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> alloc_idx == nxt($past(squash_idx)));

    // R6: a ready head that is not taken stays offered with the same contents.
    p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_ready) |=> deq_valid && $stable(deq_tag)
            && $stable(deq_data) && $stable(deq_addr) && $stable(deq_is_store));
endmodule

bind mem_trk_queue mtq_checker #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW), .DW(DW), .TW(TW)
) u_mtq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .alloc_idx    (alloc_idx),
    .full         (full),
    .empty        (empty),
    .squash_valid (squash_valid),
    .squash_idx   (squash_idx),
    .deq_valid    (deq_valid),
    .deq_ready    (deq_ready),
    .deq_is_store (deq_is_store),
    .deq_tag      (deq_tag),
    .deq_addr     (deq_addr),
    .deq_data     (deq_data)
);

// File: tb/mem_trk_queue_bench.sv
`timescale 1ns/1ps
module mem_trk_queue_bench;
    localparam int D  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_v = 0, a_st = 0, p_v = 0, r_v = 0, s_v = 0, d_r = 0;
    logic [IW-1:0] p_i = 0, r_i = 0, s_i = 0;
    logic [31:0]   p_a = 0, p_d = 0;
    logic [7:0]    cur = 0;
    logic          alloc_ready, full, deq_valid, deq_is_store;
    logic [IW-1:0] alloc_idx;
    logic [7:0]    deq_tag;
    logic [31:0]   deq_addr, deq_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model
    bit        m_st[D], m_ret[D], m_perf[D];
    int        m_tag[D];
    longint    m_addr[D], m_data[D];
    int        m_head = 0, m_count = 0;

    always #10 clk = ~clk;

    mem_trk_queue u_mem_trk_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(a_v), .alloc_is_store(a_st), .alloc_ready(alloc_ready),
        .alloc_idx(alloc_idx), .full(full),
        .perf_valid(p_v), .perf_idx(p_i), .perf_addr(p_a), .perf_data(p_d),
        .cur_interval(cur),
        .ret_valid(r_v), .ret_idx(r_i),
        .squash_valid(s_v), .squash_idx(s_i),
        .deq_valid(deq_valid), .deq_ready(d_r), .deq_is_store(deq_is_store),
        .deq_tag(deq_tag), .deq_addr(deq_addr), .deq_data(deq_data)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_tail();
        return (m_head + m_count) % D;
    endfunction

    // Compare outputs with the model, advance the model, let one edge pass.
    task automatic cycle();
        bit e_full, e_rdy, e_dv, afire, dfire;
        int sq_off;
        #1;
        e_full = (m_count == D);
        e_rdy  = !e_full && !s_v;
        e_dv   = (m_count > 0) && m_ret[m_head] && m_perf[m_head];
        chk("R3", "full", full, e_full);
        chk("R3", "alloc_ready", alloc_ready, e_rdy);
        chk("R2", "alloc_idx", alloc_idx, m_tail());
        chk("R5", "deq_valid", deq_valid, e_dv);
        if (e_dv) begin
            chk("R4", "deq_tag", deq_tag, m_tag[m_head]);
            chk("R4", "deq_addr", deq_addr, m_addr[m_head]);
            chk("R6", "deq_data", deq_data, m_data[m_head]);
            chk("R6", "deq_is_store", deq_is_store, m_st[m_head]);
        end
        afire = a_v && e_rdy;
        dfire = e_dv && d_r;
        if (p_v) begin
            m_perf[p_i] = 1; m_tag[p_i] = cur; m_data[p_i] = p_d;
            m_addr[p_i] = m_st[p_i] ? longint'(p_a) : 0;
        end
        if (r_v) m_ret[r_i] = 1;
        if (s_v) begin
            sq_off  = (int'(s_i) - m_head + D) % D;
            m_count = sq_off + 1 - int'(dfire);
        end else begin
            if (afire) begin
                m_st[m_tail()] = a_st; m_ret[m_tail()] = 0; m_perf[m_tail()] = 0;
                m_tag[m_tail()] = 0; m_addr[m_tail()] = 0; m_data[m_tail()] = 0;
            end
            m_count = m_count + int'(afire) - int'(dfire);
        end
        if (dfire) m_head = (m_head + 1) % D;
        @(negedge clk);
        a_v = 0; a_st = 0; p_v = 0; r_v = 0; s_v = 0; d_r = 0;
    endtask

    task automatic rand_cycle();
        int k0, k, idx;
        k0 = -1;
        for (int j = 0; j < m_count; j++)
            if (k0 < 0 && !m_ret[(m_head + j) % D]) k0 = j;
        d_r = ($urandom % 10) < 7;
        if ($urandom % 10 == 0) cur = cur + 1;
        if (k0 >= 0 && $urandom % 40 == 0) begin
            s_v = 1;
            s_i = IW'((m_head + k0 + int'($urandom % (m_count - k0))) % D);
            a_v = $urandom % 2;
        end else begin
            a_v = ($urandom % 10) < 6; a_st = $urandom % 2;
            if (m_count > 0 && $urandom % 2 == 1) begin
                k = $urandom % m_count; idx = (m_head + k) % D;
                if (!m_perf[idx]) begin
                    p_v = 1; p_i = IW'(idx); p_a = $urandom; p_d = $urandom;
                end
            end
            if (k0 >= 0 && $urandom % 2 == 1) begin
                r_v = 1; r_i = IW'((m_head + k0) % D);
            end
        end
        cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "full", full, 0);
        chk("R1", "deq_valid", deq_valid, 0);
        chk("R1", "alloc_idx", alloc_idx, 0);
        chk("R1", "alloc_ready", alloc_ready, 1);
        @(negedge clk);
        // fill; entry 1 is a store
        for (int i = 0; i < D; i++) begin
            a_v = 1; a_st = (i == 1); cycle();
        end
        #1;
        chk("R3", "full after fill", full, 1);
        a_v = 1; cycle();
        #1;
        chk("R3", "alloc ignored while full", alloc_idx, 0);
        // R5: retired but not performed load
        r_v = 1; r_i = 0; cycle();
        #1; chk("R5", "retired only", deq_valid, 0);
        p_v = 1; p_i = 0; cur = 8'd5; p_a = 32'hDEAD; p_d = 32'hAAAA; cycle();
        #1;
        chk("R5", "ready head", deq_valid, 1);
        chk("R4", "load tag", deq_tag, 5);
        chk("R4", "load addr zero", deq_addr, 0);
        // R7: store retired before perform
        r_v = 1; r_i = 1; cycle();
        d_r = 1; cycle();
        #1; chk("R7", "retired store unperformed", deq_valid, 0);
        p_v = 1; p_i = 1; cur = 8'd7; p_a = 32'h1234; p_d = 32'h55; cycle();
        #1;
        chk("R4", "store type", deq_is_store, 1);
        chk("R4", "store addr", deq_addr, 32'h1234);
        chk("R4", "store tag", deq_tag, 7);
        // R6: entry 3 ready behind unperformed entry 2
        r_v = 1; r_i = 2; cycle();
        r_v = 1; r_i = 3; p_v = 1; p_i = 3; p_d = 32'h33; cycle();
        d_r = 1; cycle();
        #1; chk("R6", "younger ready held", deq_valid, 0);
        // R8: squash at 8 with a competing allocation
        s_v = 1; s_i = 4'd8; a_v = 1; cycle();
        #1;
        chk("R8", "next index after squash", alloc_idx, 9);
        chk("R8", "not full after squash", full, 0);
        // R9: allocate and release together
        p_v = 1; p_i = 2; p_d = 32'h22; cycle();
        a_v = 1; d_r = 1; cycle();
        #1;
        chk("R9", "index after alloc+deq", alloc_idx, m_tail());
        chk("R9", "next head ready", deq_valid, 1);
        // random phase
        for (int n = 0; n < 4000; n++) rand_cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule